// File: doc/BRIEF.md
# Hashed Load-Reserve / Store-Conditional Monitor

This block keeps a shared table of atomic reservations for several hardware threads. A thread issues a reserve on an address. It receives a generation tag, and later it attempts a conditional commit with that tag. The commit passes only if nothing has disturbed the reservation in between. Plain stores from any thread are sent through the same command port as invalidates, so that a store to a reserved 128-byte line breaks the reservation. A release drops a reservation without reporting a result. The block only judges success. The data write belongs to the requester.

The table is direct-mapped. Each slot holds a packed record of line address, generation and thread ID. Lines that share an index displace each other on reserve. An invalidate clears a slot only when the slot's stored line matches the store's line. A global generation counter stamps every reserve, so a later reserve on a slot always wins over an earlier one. A counter of occupied slots drives an "any reservation active" flag, which store paths can use to skip the invalidate. All responses are registered and appear one cycle after the request.

Top module: `resv_monitor`

## Requirements
- R1: The line address is the request address with bits 6:0 cleared. The slot index is line address bits [7 +: log2(ENTRIES)]. Addresses that differ only in bits 6:0 address the same reservation.
- R2: A reserve (req_op = 0) made while tbl_en is high returns the current generation on rsp_gen one cycle later, with rsp_vld high. After reset the generation starts at 1 and advances by one per enabled reserve. Every request, whatever its op or enable, gives rsp_vld high exactly one cycle later.
- R3: When the GEN_W-bit generation would wrap to 0, it becomes 1 instead, so 0 is never issued by an enabled reserve.
- R4: A reserve overwrites its slot unconditionally. A commit with the displaced holder's generation and thread then fails, and the newer holder's commit passes.
- R5: A commit (req_op = 1) sets rsp_pass only when the slot holds exactly {line, generation, thread}. It then empties the slot, so a repeated commit fails. A stale generation fails and changes nothing.
- R6: A commit whose thread ID differs from the reserving thread fails and leaves the reservation intact, even when line and generation match.
- R7: A store invalidate (req_op = 3) empties the slot only if the slot is occupied by the same line. A different line mapping to the same index is left untouched.
- R8: A release (req_op = 2) empties a matching slot like a commit, but rsp_pass stays 0. A release that does not match changes nothing.
- R9: any_active is high exactly when at least one slot is occupied. It rises in the cycle after a reserve into an empty slot, it is unchanged by a reserve that displaces another holder, and it falls in the cycle after the last occupied slot is emptied.
- R10: With tbl_en low, a reserve returns generation 0 and does not advance the counter, a commit reports fail, and an invalidate or release is ignored. The table and the count are unchanged.
- R11: Reset empties every slot in one cycle. It clears rsp_vld, rsp_pass, rsp_gen and any_active, and it restarts the generation at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_en | input | 1 | Table enable; when low, requests answer without effect |
| req_vld | input | 1 | Request strobe, one request per cycle |
| req_op | input | 2 | 0 reserve, 1 commit, 2 release, 3 store invalidate |
| req_addr | input | 32 | Byte address of the access |
| req_tid | input | 8 | Requesting hardware thread ID |
| req_gen | input | GEN_W | Generation tag for commit and release |
| rsp_vld | output | 1 | Response strobe, one cycle after req_vld |
| rsp_gen | output | GEN_W | Generation granted by a reserve, else 0 |
| rsp_pass | output | 1 | Commit succeeded |
| any_active | output | 1 | At least one reservation outstanding |

## Verification
A single reserve does two things in the same cycle. It installs a new holder, and it evicts whatever reservation occupied the slot. The occupancy count must then hold steady instead of rising. The bench provokes this by having a second thread reserve a line that is already held. It judges the result three ways: the displaced commit fails, the new holder's commit passes, and any_active stays high until that commit and falls right after it. A second pairing is a commit or release that follows a reserve on the same slot in the very next cycle, which exercises read-after-write through the table. The disabled path and a colliding-line invalidate are checked by later commits that must still pass.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    OP_RSV = 2'd0,
    OP_CMT = 2'd1,
    OP_REL = 2'd2,
    OP_INV = 2'd3
  } op_e;

  localparam int LINE_SH   = 7;
  localparam int ENT_W     = 64;
  localparam logic [31:0] LINE_MASK = 32'hFFFF_FF80;

  // slot layout: [63:32] line address, [31:8] generation, [7:0] thread
  function automatic logic [ENT_W-1:0] pack_ent(input logic [31:0] line,
                                                input logic [23:0] gen,
                                                input logic [7:0]  tid);
    return {line, gen, tid};
  endfunction

endpackage

// File: rtl/resv_table.sv
module resv_table #(
  parameter int ENTRIES = 4096,
  parameter int W       = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             clr_en,
  output logic [W-1:0]     rd_data,
  output logic             rd_vld
);

  logic [W-1:0]       mem [ENTRIES];
  logic [ENTRIES-1:0] occ;

  // data array: no reset, write only, so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wr_data;
  end

  // occupancy bits: flash-cleared on reset
  always_ff @(posedge clk) begin
    if (rst)         occ      <= '0;
    else if (wr_en)  occ[idx] <= 1'b1;
    else if (clr_en) occ[idx] <= 1'b0;
  end

  assign rd_data = mem[idx];
  assign rd_vld  = occ[idx];

  p_wr_clr_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && clr_en));

  p_clr_needs_occ_r5: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> rd_vld);

endmodule

// File: rtl/resv_gen_ctr.sv
module resv_gen_ctr #(
  parameter int GEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [GEN_W-1:0] cur
);

  logic [GEN_W-1:0] nxt;

  always_comb begin
    nxt = cur + 1'b1;
    if (nxt == '0) nxt = GEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)      cur <= GEN_W'(1);
    else if (adv) cur <= nxt;
  end

  p_wrap_skips_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $past(adv && (cur == '1)) |-> (cur == GEN_W'(1)));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(adv) |-> $stable(cur));

endmodule

// File: rtl/resv_count.sv
module resv_count #(
  parameter int ENTRIES = 4096,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             any_active
);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (inc)      cnt_nxt = cnt + 1'b1;
    else if (dec) cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      any_active <= 1'b0;
    end else begin
      cnt        <= cnt_nxt;
      any_active <= (cnt_nxt != '0);
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    inc |-> (cnt != CNT_W'(ENTRIES)));

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt != '0));

  p_rise_after_inc_r9: assert property (@(posedge clk) disable iff (rst)
    inc |=> any_active);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ENTRIES = 4096,
  parameter int GEN_W   = 24,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbl_en,
  input  logic             req_vld,
  input  logic [1:0]       req_op,
  input  logic [31:0]      req_addr,
  input  logic [7:0]       req_tid,
  input  logic [GEN_W-1:0] req_gen,
  output logic             rsp_vld,
  output logic [GEN_W-1:0] rsp_gen,
  output logic             rsp_pass,
  output logic             any_active
);

  op_e              op;
  logic [31:0]      line;
  logic [IDX_W-1:0] idx;
  logic [ENT_W-1:0] slot, want, stamp;
  logic             slot_vld, go, exact, same_line;
  logic             do_rsv, do_chk, do_inv, clr;
  logic [GEN_W-1:0] gen_cur;
  logic [CNT_W-1:0] cnt;

  assign op   = op_e'(req_op);
  assign line = req_addr & LINE_MASK;
  assign idx  = IDX_W'(line >> LINE_SH);
  assign go   = req_vld && tbl_en;

  assign want      = pack_ent(line, 24'(req_gen), req_tid);
  assign stamp     = pack_ent(line, 24'(gen_cur), req_tid);
  assign exact     = slot_vld && (slot == want);
  assign same_line = slot_vld && (slot[63:32] == line);

  assign do_rsv = go && (op == OP_RSV);
  assign do_chk = go && ((op == OP_CMT) || (op == OP_REL)) && exact;
  assign do_inv = go && (op == OP_INV) && same_line;
  assign clr    = do_chk || do_inv;

  resv_table #(.ENTRIES(ENTRIES), .W(ENT_W)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .idx     (idx),
    .wr_en   (do_rsv),
    .wr_data (stamp),
    .clr_en  (clr),
    .rd_data (slot),
    .rd_vld  (slot_vld)
  );

  resv_gen_ctr #(.GEN_W(GEN_W)) u_gen (
    .clk (clk),
    .rst (rst),
    .adv (do_rsv),
    .cur (gen_cur)
  );

  resv_count #(.ENTRIES(ENTRIES)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .inc        (do_rsv && !slot_vld),
    .dec        (clr),
    .cnt        (cnt),
    .any_active (any_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld  <= 1'b0;
      rsp_gen  <= '0;
      rsp_pass <= 1'b0;
    end else begin
      rsp_vld  <= req_vld;
      rsp_gen  <= do_rsv ? gen_cur : '0;
      rsp_pass <= go && (op == OP_CMT) && exact;
    end
  end

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);

  p_rsv_gen_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    $past(do_rsv) |-> (rsp_gen != '0));

  p_disabled_inert_r10: assert property (@(posedge clk) disable iff (rst)
    $past(req_vld && !tbl_en) |-> ((rsp_gen == '0) && !rsp_pass));

  p_pass_drops_count_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_pass |-> (cnt == CNT_W'($past(cnt) - 1'b1)));

endmodule

// File: tb/sim_resv_monitor.sv
module sim_resv_monitor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_en = 1'b0;
  logic        req_vld = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_tid = '0;
  logic [23:0] req_gen = '0;
  logic        rsp_vld, rsp_pass, any_active;
  logic [23:0] rsp_gen;

  // small instance for generation wrap
  logic        b_vld = 1'b0;
  logic        b_vldo, b_pass, b_act;
  logic [2:0]  b_gen;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  resv_monitor u0 (
    .clk(clk), .rst(rst), .tbl_en(tbl_en), .req_vld(req_vld), .req_op(req_op),
    .req_addr(req_addr), .req_tid(req_tid), .req_gen(req_gen),
    .rsp_vld(rsp_vld), .rsp_gen(rsp_gen), .rsp_pass(rsp_pass), .any_active(any_active)
  );

  resv_monitor #(.ENTRIES(8), .GEN_W(3)) u1 (
    .clk(clk), .rst(rst), .tbl_en(1'b1), .req_vld(b_vld), .req_op(2'd0),
    .req_addr(32'h0000_0100), .req_tid(8'd9), .req_gen(3'd0),
    .rsp_vld(b_vldo), .rsp_gen(b_gen), .rsp_pass(b_pass), .any_active(b_act)
  );

  // {en, op, addr, tid, gen, exp_gen, exp_pass, exp_active, tag}
  localparam int NV = 31;
  localparam logic [100:0] VEC [NV] = '{
    {1'b1,2'd0,32'h1000_0040,8'd1,24'd0,24'd1, 1'b0,1'b1,8'd2},  // R2 first gen 1
    {1'b1,2'd1,32'h1000_0000,8'd1,24'd1,24'd0, 1'b1,1'b0,8'd1},  // R1 low bits ignored, R5
    {1'b1,2'd1,32'h1000_0000,8'd1,24'd1,24'd0, 1'b0,1'b0,8'd5},  // R5 second commit fails
    {1'b1,2'd0,32'h1000_0000,8'd2,24'd0,24'd2, 1'b0,1'b1,8'd2},
    {1'b1,2'd1,32'h1000_0000,8'd3,24'd2,24'd0, 1'b0,1'b1,8'd6},  // R6 foreign thread
    {1'b1,2'd1,32'h1000_0000,8'd2,24'd2,24'd0, 1'b1,1'b0,8'd6},  // R6 owner passes
    {1'b1,2'd0,32'h1000_0000,8'd1,24'd0,24'd3, 1'b0,1'b1,8'd4},
    {1'b1,2'd0,32'h1000_0010,8'd2,24'd0,24'd4, 1'b0,1'b1,8'd9},  // R9 displace, count holds
    {1'b1,2'd1,32'h1000_0000,8'd1,24'd3,24'd0, 1'b0,1'b1,8'd4},  // R4 displaced fails
    {1'b1,2'd1,32'h1000_0000,8'd2,24'd4,24'd0, 1'b1,1'b0,8'd4},  // R4 newer passes
    {1'b1,2'd0,32'h1000_0000,8'd1,24'd0,24'd5, 1'b0,1'b1,8'd2},
    {1'b1,2'd3,32'h1008_0000,8'd7,24'd0,24'd0, 1'b0,1'b1,8'd7},  // R7 colliding line kept
    {1'b1,2'd1,32'h1000_0000,8'd1,24'd5,24'd0, 1'b1,1'b0,8'd7},
    {1'b1,2'd0,32'h1000_0000,8'd1,24'd0,24'd6, 1'b0,1'b1,8'd2},
    {1'b1,2'd3,32'h1000_007C,8'd7,24'd0,24'd0, 1'b0,1'b0,8'd7},  // R7 same line cleared
    {1'b1,2'd1,32'h1000_0000,8'd1,24'd6,24'd0, 1'b0,1'b0,8'd7},
    {1'b1,2'd0,32'h1000_0000,8'd4,24'd0,24'd7, 1'b0,1'b1,8'd2},
    {1'b1,2'd2,32'h1000_0000,8'd4,24'd7,24'd0, 1'b0,1'b0,8'd8},  // R8 release, no pass
    {1'b1,2'd1,32'h1000_0000,8'd4,24'd7,24'd0, 1'b0,1'b0,8'd8},
    {1'b1,2'd0,32'h2000_0100,8'd5,24'd0,24'd8, 1'b0,1'b1,8'd2},
    {1'b1,2'd1,32'h2000_0100,8'd5,24'd7,24'd0, 1'b0,1'b1,8'd5},  // R5 stale gen
    {1'b0,2'd0,32'h2000_0100,8'd6,24'd0,24'd0, 1'b0,1'b1,8'd10}, // R10 disabled reserve
    {1'b0,2'd1,32'h2000_0100,8'd5,24'd8,24'd0, 1'b0,1'b1,8'd10},
    {1'b0,2'd3,32'h2000_0100,8'd5,24'd0,24'd0, 1'b0,1'b1,8'd10},
    {1'b1,2'd1,32'h2000_0100,8'd5,24'd8,24'd0, 1'b1,1'b0,8'd10}, // R10 table untouched
    {1'b1,2'd0,32'h2000_0100,8'd5,24'd0,24'd9, 1'b0,1'b1,8'd10}, // R10 counter not advanced
    {1'b1,2'd2,32'h2000_0100,8'd5,24'd9,24'd0, 1'b0,1'b0,8'd8},
    {1'b1,2'd0,32'h1000_0000,8'd1,24'd0,24'd10,1'b0,1'b1,8'd9},
    {1'b1,2'd0,32'h2000_0100,8'd2,24'd0,24'd11,1'b0,1'b1,8'd9},
    {1'b1,2'd1,32'h1000_0000,8'd1,24'd10,24'd0,1'b1,1'b1,8'd9},  // R9 one still held
    {1'b1,2'd1,32'h2000_0100,8'd2,24'd11,24'd0,1'b1,1'b0,8'd9}
  };

  task automatic chk(input bit ok, input int tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [1:0] op, input logic [31:0] a,
                      input logic [7:0] tid, input logic [23:0] g);
    tbl_en   = en;
    req_vld  = 1'b1;
    req_op   = op;
    req_addr = a;
    req_tid  = tid;
    req_gen  = g;
    @(negedge clk);
    req_vld  = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(rsp_vld == 1'b0, 11, "rsp_vld in reset", 32'(rsp_vld), 0);
    chk(any_active == 1'b0, 11, "any_active in reset", 32'(any_active), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [100:0] v;
      int tag;
      v = VEC[i];
      tag = int'(v[7:0]);
      step(v[100], v[99:98], v[97:66], v[65:58], v[57:34]);
      chk(rsp_vld == 1'b1, 2, "rsp_vld", 32'(rsp_vld), 1);
      chk(rsp_gen == v[33:10], tag, "rsp_gen", 32'(rsp_gen), 32'(v[33:10]));
      chk(rsp_pass == v[9], tag, "rsp_pass", 32'(rsp_pass), 32'(v[9]));
      chk(any_active == v[8], tag, "any_active", 32'(any_active), 32'(v[8]));
    end

    @(negedge clk);
    chk(rsp_vld == 1'b0, 2, "rsp_vld idle", 32'(rsp_vld), 0);

    // R11 mid-run reset empties table and restarts generation
    step(1'b1, 2'd0, 32'h1000_0000, 8'd1, 24'd0);
    chk(rsp_gen == 24'd12 && any_active, 11, "gen before reset", 32'(rsp_gen), 12);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(any_active == 1'b0, 11, "any_active after reset", 32'(any_active), 0);
    chk(rsp_vld == 1'b0 && rsp_gen == '0, 11, "rsp after reset", 32'(rsp_gen), 0);
    rst = 1'b0;
    @(negedge clk);
    step(1'b1, 2'd1, 32'h1000_0000, 8'd1, 24'd12);
    chk(rsp_pass == 1'b0, 11, "old reservation gone", 32'(rsp_pass), 0);
    step(1'b1, 2'd0, 32'h1000_0000, 8'd1, 24'd0);
    chk(rsp_gen == 24'd1, 11, "gen restarts", 32'(rsp_gen), 1);

    // R3 wrap on a 3-bit generation: 1..7 then 1
    for (int k = 0; k < 8; k++) begin
      logic [2:0] e;
      e = (k == 7) ? 3'd1 : 3'(k + 1);
      b_vld = 1'b1;
      @(negedge clk);
      b_vld = 1'b0;
      chk(b_vldo && b_gen == e, 3, "wrapped gen", 32'(b_gen), 32'(e));
      chk(b_pass == 1'b0 && b_act == 1'b1, 3, "wrap side flags", 32'(b_pass), 0);
    end

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog expired: actual hung expected done");
    finish_run();
  end

endmodule